// File: doc/BRIEF.md
# Sector test pattern generator/checker

This block produces a stream of 32-bit test words for a storage write and checks a read-back stream against the same words. Data is organised in sectors of 128 words (512 bytes). Each sector opens with a two-word header that holds the sector's own logical block address. The remaining words follow a selectable pattern derived from that address, so a sector that lands at the wrong place on the medium fails the check.

A command starts with a one-cycle start pulse. The pulse carries the start address in sectors, the length in sectors, the pattern select and a read/write mode, and all of these are sampled at that moment.

- **Write mode:** the block pushes words into a downstream FIFO and holds off while that FIFO reports almost-full.
- **Read mode:** it drains an upstream show-ahead FIFO whenever the FIFO is not empty. It compares each word with the regenerated expected value and keeps the first mismatch: its absolute byte address, the expected word and the received word.
- **Progress:** a running byte count reports how far the transfer has got.

Top module: `sector_patgen`

## Requirements
- R1: After reset, busy_o, wr_en_o, rd_en_o and fail_o are low and tested_bytes_o is zero, whatever the FIFO flags show.
- R2: A start pulse taken while idle raises busy_o on the next cycle if sector_cnt_i is non-zero. With a zero length, busy_o stays low and no FIFO enable is ever raised.
- R3: In write mode wr_en_o is high exactly when busy_o is high and wr_afull_i is low, so the stream pauses while almost-full is high.
- R4: In read mode rd_en_o is high exactly when busy_o is high and rd_empty_i is low. rd_data_i is taken in the cycle rd_en_o is high (show-ahead FIFO). wr_en_o stays low in read mode.
- R5: Every enabled word adds 4 to tested_bytes_o. After exactly sector_cnt_i*128 enabled words, busy_o falls and the enables stop.
- R6: Word 0 of a sector is LBA[31:0] and word 1 is LBA[47:32] zero-extended. The LBA starts at start_lba_i and rises by one after each full sector.
- R7: For words 2..127, the pattern select works as follows:
  - 3'b000 gives {LBA[24:0], word index[6:0]};
  - 3'b001 gives the bitwise inverse of that;
  - 3'b010 gives all zeros;
  - 3'b011 gives all ones;
  - the codes 3'b101..3'b111 give all zeros.
- R8: Pattern select 3'b100 gives an LFSR pattern with polynomial x^31+x^21+x+1. The step is s -> {s[30:0], s[30]^s[20]^s[0]}. Word k (2..127) equals this step applied k-1 times to the sector's LBA[31:0], so the pattern is reseeded in every sector.
- R9: In read mode a word that differs from the expected word sets fail_o, which stays set. The first mismatch alone is captured: fail_addr_o = {LBA, word index, 2'b00} (57 bits), with fail_exp_o and fail_got_o holding the expected and received words.
- R10: The next accepted start pulse clears fail_o and the captured values.
- R11: A start pulse while busy_o is high is ignored: the address, length, pattern and progress of the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle command start |
| rd_mode_i | input | 1 | 1 = read and check, 0 = write; sampled at start |
| start_lba_i | input | 48 | First sector address |
| sector_cnt_i | input | 48 | Transfer length in sectors |
| patt_sel_i | input | 3 | Pattern select; sampled at start |
| wr_afull_i | input | 1 | Downstream FIFO almost-full |
| wr_en_o | output | 1 | Downstream FIFO write enable |
| wr_data_o | output | 32 | Downstream FIFO write data |
| rd_empty_i | input | 1 | Upstream FIFO empty |
| rd_en_o | output | 1 | Upstream FIFO read enable |
| rd_data_i | input | 32 | Upstream FIFO head word |
| busy_o | output | 1 | Transfer in progress |
| fail_o | output | 1 | Sticky compare failure |
| fail_addr_o | output | 57 | Byte address of first mismatch |
| fail_exp_o | output | 32 | Expected word at first mismatch |
| fail_got_o | output | 32 | Received word at first mismatch |
| tested_bytes_o | output | 57 | Bytes transferred in the current command |

## Verification
The hardest situation to reach is a second mismatch after the first one has been captured, together with an empty FIFO that stalls the read stream. Under that stall the checker must neither advance nor re-capture. The read scenario feeds a stream with two corrupted words, one in the first sector and one in the second, while the empty flag drops out in a fixed rhythm. The captured address and words must then point at the earlier corruption only. A later clean read proves the capture is cleared. A second start pulse is also injected mid-transfer, where it has to be ignored.

// File: rtl/sector_patgen_pkg.sv
package sector_patgen_pkg;

   localparam int unsigned WORD_W = 32;

   typedef enum logic [2:0] {
      PAT_INC  = 3'b000,
      PAT_DEC  = 3'b001,
      PAT_ZERO = 3'b010,
      PAT_ONE  = 3'b011,
      PAT_LFSR = 3'b100
   } pat_sel_e;

   // One step of the x^31 + x^21 + x + 1 shift sequence
   function automatic logic [WORD_W-1:0] lfsr_advance(input logic [WORD_W-1:0] s);
      return {s[WORD_W-2:0], s[30] ^ s[20] ^ s[0]};
   endfunction

endpackage

// File: rtl/sector_patgen_seq.sv
module sector_patgen_seq
   import sector_patgen_pkg::*;
#(
   parameter int unsigned LBA_W     = 48,
   parameter int unsigned SEC_WORDS = 128,
   localparam int unsigned WIDX_W   = $clog2(SEC_WORDS),
   localparam int unsigned CNT_W    = LBA_W + WIDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rd_mode_i,
   input  logic [LBA_W-1:0]  start_lba_i,
   input  logic [LBA_W-1:0]  sec_cnt_i,
   input  logic [2:0]        patt_i,
   input  logic              afull_i,
   input  logic              empty_i,
   output logic              busy_o,
   output logic              wr_en_o,
   output logic              rd_en_o,
   output logic              start_ok_o,
   output logic [LBA_W-1:0]  lba_o,
   output logic [WIDX_W-1:0] widx_o,
   output logic [CNT_W-1:0]  cnt_o,
   output pat_sel_e          patt_o
);

   logic             active_q;
   logic             rd_q;
   pat_sel_e         patt_q;
   logic [LBA_W-1:0] lba_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] end_q;
   logic             step;
   logic             last_word;
   logic [CNT_W-1:0] cnt_nxt;

   assign start_ok_o = start_i & ~active_q;
   assign wr_en_o    = active_q & ~rd_q & ~afull_i;
   assign rd_en_o    = active_q &  rd_q & ~empty_i;
   assign step       = wr_en_o | rd_en_o;
   assign cnt_nxt    = cnt_q + CNT_W'(1);
   assign last_word  = (cnt_q[WIDX_W-1:0] == WIDX_W'(SEC_WORDS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rd_q     <= 1'b0;
         patt_q   <= PAT_INC;
         lba_q    <= '0;
         cnt_q    <= '0;
         end_q    <= '0;
      end else if (start_ok_o) begin
         active_q <= (sec_cnt_i != '0);
         rd_q     <= rd_mode_i;
         patt_q   <= pat_sel_e'(patt_i);
         lba_q    <= start_lba_i;
         cnt_q    <= '0;
         end_q    <= {sec_cnt_i, {WIDX_W{1'b0}}};
      end else if (step) begin
         cnt_q <= cnt_nxt;
         if (last_word) lba_q <= lba_q + LBA_W'(1);
         if (cnt_nxt == end_q) active_q <= 1'b0;
      end
   end

   assign busy_o = active_q;
   assign lba_o  = lba_q;
   assign widx_o = cnt_q[WIDX_W-1:0];
   assign cnt_o  = cnt_q;
   assign patt_o = patt_q;

endmodule

// File: rtl/sector_patgen_word.sv
module sector_patgen_word
   import sector_patgen_pkg::*;
#(
   parameter int unsigned LBA_W     = 48,
   parameter int unsigned SEC_WORDS = 128,
   parameter bit          LFSR_EN   = 1'b1,
   localparam int unsigned WIDX_W   = $clog2(SEC_WORDS),
   localparam int unsigned LOW_W    = WORD_W - WIDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic [LBA_W-1:0]  lba_i,
   input  logic [WIDX_W-1:0] widx_i,
   input  pat_sel_e          patt_i,
   output logic [WORD_W-1:0] word_o
);

   logic [WORD_W-1:0] hdr0;
   logic [WORD_W-1:0] hdr1;
   logic [WORD_W-1:0] ramp;
   logic [WORD_W-1:0] lfsr_word;

   // Header halves: address width picks the split
   if (LBA_W > WORD_W) begin : g_hdr_wide
      assign hdr0 = lba_i[WORD_W-1:0];
      assign hdr1 = WORD_W'(lba_i[LBA_W-1:WORD_W]);
   end else begin : g_hdr_narrow
      assign hdr0 = WORD_W'(lba_i);
      assign hdr1 = '0;
   end

   assign ramp = {lba_i[LOW_W-1:0], widx_i};

   // Sequence register, reseeded from the header on word 1
   if (LFSR_EN) begin : g_lfsr
      logic [WORD_W-1:0] lfsr_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            lfsr_q <= '0;
         else if (step_i)
            lfsr_q <= lfsr_advance((widx_i == WIDX_W'(1)) ? hdr0 : lfsr_q);
      end
      assign lfsr_word = lfsr_q;
   end else begin : g_no_lfsr
      assign lfsr_word = '0;
   end

   always_comb begin
      if (widx_i == '0)
         word_o = hdr0;
      else if (widx_i == WIDX_W'(1))
         word_o = hdr1;
      else begin
         case (patt_i)
            PAT_INC:  word_o = ramp;
            PAT_DEC:  word_o = ~ramp;
            PAT_ZERO: word_o = '0;
            PAT_ONE:  word_o = '1;
            PAT_LFSR: word_o = lfsr_word;
            default:  word_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/sector_patgen_cmp.sv
module sector_patgen_cmp
   import sector_patgen_pkg::*;
#(
   parameter int unsigned LBA_W     = 48,
   parameter int unsigned SEC_WORDS = 128,
   localparam int unsigned WIDX_W   = $clog2(SEC_WORDS),
   localparam int unsigned ADDR_W   = LBA_W + WIDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              rd_en_i,
   input  logic [WORD_W-1:0] got_i,
   input  logic [WORD_W-1:0] exp_i,
   input  logic [LBA_W-1:0]  lba_i,
   input  logic [WIDX_W-1:0] widx_i,
   output logic              fail_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [WORD_W-1:0] exp_o,
   output logic [WORD_W-1:0] got_o
);

   logic              fail_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] exp_q;
   logic [WORD_W-1:0] got_q;
   logic              miss;

   assign miss = rd_en_i && (got_i != exp_i);

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         fail_q <= 1'b0;
         addr_q <= '0;
         exp_q  <= '0;
         got_q  <= '0;
      end else if (miss && !fail_q) begin
         fail_q <= 1'b1;
         addr_q <= {lba_i, widx_i, 2'b00};
         exp_q  <= exp_i;
         got_q  <= got_i;
      end
   end

   assign fail_o = fail_q;
   assign addr_o = addr_q;
   assign exp_o  = exp_q;
   assign got_o  = got_q;

endmodule

// File: rtl/sector_patgen.sv
module sector_patgen
   import sector_patgen_pkg::*;
#(
   parameter int unsigned LBA_W     = 48,
   parameter int unsigned SEC_WORDS = 128,
   parameter bit          LFSR_EN   = 1'b1,
   localparam int unsigned WIDX_W   = $clog2(SEC_WORDS),
   localparam int unsigned CNT_W    = LBA_W + WIDX_W,
   localparam int unsigned BYTE_W   = CNT_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rd_mode_i,
   input  logic [LBA_W-1:0]  start_lba_i,
   input  logic [LBA_W-1:0]  sector_cnt_i,
   input  logic [2:0]        patt_sel_i,
   input  logic              wr_afull_i,
   output logic              wr_en_o,
   output logic [WORD_W-1:0] wr_data_o,
   input  logic              rd_empty_i,
   output logic              rd_en_o,
   input  logic [WORD_W-1:0] rd_data_i,
   output logic              busy_o,
   output logic              fail_o,
   output logic [BYTE_W-1:0] fail_addr_o,
   output logic [WORD_W-1:0] fail_exp_o,
   output logic [WORD_W-1:0] fail_got_o,
   output logic [BYTE_W-1:0] tested_bytes_o
);

   if (SEC_WORDS < 4 || (SEC_WORDS & (SEC_WORDS - 1)) != 0) begin : g_bad_sector
      $error("SEC_WORDS must be a power of two of at least 4");
   end
   if (LBA_W < WORD_W - WIDX_W || LBA_W > 2 * WORD_W) begin : g_bad_lba
      $error("LBA_W out of supported range");
   end

   logic              start_ok;
   logic [LBA_W-1:0]  lba;
   logic [WIDX_W-1:0] widx;
   logic [CNT_W-1:0]  cnt;
   pat_sel_e          patt;
   logic [WORD_W-1:0] exp_word;

   sector_patgen_seq #(.LBA_W(LBA_W), .SEC_WORDS(SEC_WORDS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .rd_mode_i   (rd_mode_i),
      .start_lba_i (start_lba_i),
      .sec_cnt_i   (sector_cnt_i),
      .patt_i      (patt_sel_i),
      .afull_i     (wr_afull_i),
      .empty_i     (rd_empty_i),
      .busy_o      (busy_o),
      .wr_en_o     (wr_en_o),
      .rd_en_o     (rd_en_o),
      .start_ok_o  (start_ok),
      .lba_o       (lba),
      .widx_o      (widx),
      .cnt_o       (cnt),
      .patt_o      (patt)
   );

   sector_patgen_word #(.LBA_W(LBA_W), .SEC_WORDS(SEC_WORDS), .LFSR_EN(LFSR_EN)) u_word (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (wr_en_o | rd_en_o),
      .lba_i  (lba),
      .widx_i (widx),
      .patt_i (patt),
      .word_o (exp_word)
   );

   sector_patgen_cmp #(.LBA_W(LBA_W), .SEC_WORDS(SEC_WORDS)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_ok),
      .rd_en_i (rd_en_o),
      .got_i   (rd_data_i),
      .exp_i   (exp_word),
      .lba_i   (lba),
      .widx_i  (widx),
      .fail_o  (fail_o),
      .addr_o  (fail_addr_o),
      .exp_o   (fail_exp_o),
      .got_o   (fail_got_o)
   );

   assign wr_data_o      = exp_word;
   assign tested_bytes_o = {cnt, 2'b00};

endmodule

// File: rtl/sector_patgen_sva.sv
module sector_patgen_sva #(
   parameter int unsigned LBA_W     = 48,
   parameter int unsigned SEC_WORDS = 128,
   localparam int unsigned BYTE_W   = LBA_W + $clog2(SEC_WORDS) + 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [LBA_W-1:0]  sector_cnt_i,
   input logic              wr_afull_i,
   input logic              wr_en_o,
   input logic              rd_empty_i,
   input logic              rd_en_o,
   input logic              busy_o,
   input logic              fail_o,
   input logic [BYTE_W-1:0] fail_addr_o,
   input logic [BYTE_W-1:0] tested_bytes_o
);

   logic taken;
   assign taken = start_i && !busy_o;

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      taken && (sector_cnt_i != '0) |=> busy_o);

   p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      taken && (sector_cnt_i == '0) |=> !busy_o);

   p_wr_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> busy_o && !wr_afull_i);

   p_rd_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> busy_o && !rd_empty_i);

   p_one_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_o && rd_en_o));

   p_byte_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o || rd_en_o) |=> tested_bytes_o == $past(tested_bytes_o) + BYTE_W'(4));

   p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o && !taken |=> fail_o && $stable(fail_addr_o));

   p_fail_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> !fail_o);

   p_busy_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i && !wr_en_o && !rd_en_o |=> busy_o && $stable(tested_bytes_o));

endmodule

bind sector_patgen sector_patgen_sva #(.LBA_W(LBA_W), .SEC_WORDS(SEC_WORDS)) u_sva (
   .clk            (clk),
   .rst_n          (rst_n),
   .start_i        (start_i),
   .sector_cnt_i   (sector_cnt_i),
   .wr_afull_i     (wr_afull_i),
   .wr_en_o        (wr_en_o),
   .rd_empty_i     (rd_empty_i),
   .rd_en_o        (rd_en_o),
   .busy_o         (busy_o),
   .fail_o         (fail_o),
   .fail_addr_o    (fail_addr_o),
   .tested_bytes_o (tested_bytes_o)
);

// File: tb/sector_patgen_tb_top.sv
module sector_patgen_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        rd_mode_i = 1'b0;
   logic [47:0] start_lba_i = '0;
   logic [47:0] sector_cnt_i = '0;
   logic [2:0]  patt_sel_i = '0;
   logic        wr_afull_i = 1'b0;
   logic        wr_en_o;
   logic [31:0] wr_data_o;
   logic        rd_empty_i = 1'b1;
   logic        rd_en_o;
   logic [31:0] rd_data_i = '0;
   logic        busy_o;
   logic        fail_o;
   logic [56:0] fail_addr_o;
   logic [31:0] fail_exp_o;
   logic [31:0] fail_got_o;
   logic [56:0] tested_bytes_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sector_patgen dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_mode_i(rd_mode_i),
      .start_lba_i(start_lba_i), .sector_cnt_i(sector_cnt_i), .patt_sel_i(patt_sel_i),
      .wr_afull_i(wr_afull_i), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
      .rd_empty_i(rd_empty_i), .rd_en_o(rd_en_o), .rd_data_i(rd_data_i),
      .busy_o(busy_o), .fail_o(fail_o), .fail_addr_o(fail_addr_o),
      .fail_exp_o(fail_exp_o), .fail_got_o(fail_got_o), .tested_bytes_o(tested_bytes_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] lfsr_step(input logic [31:0] s);
      return {s[30:0], s[30] ^ s[20] ^ s[0]};
   endfunction

   // Expected word from the requirement text (R6, R7, R8)
   function automatic logic [31:0] model(input logic [47:0] lba, input int w, input logic [2:0] sel);
      logic [6:0]  w7;
      logic [31:0] s;
      w7 = w[6:0];
      if (w == 0) return lba[31:0];
      if (w == 1) return {16'h0, lba[47:32]};
      case (sel)
         3'b000: return {lba[24:0], w7};
         3'b001: return ~{lba[24:0], w7};
         3'b010: return 32'h0;
         3'b011: return 32'hFFFF_FFFF;
         3'b100: begin
            s = lba[31:0];
            for (int i = 1; i < w; i++) s = lfsr_step(s);
            return s;
         end
         default: return 32'h0;
      endcase
   endfunction

   task automatic pulse_start(input bit rd, input logic [47:0] lba, input logic [47:0] n,
                              input logic [2:0] sel);
      @(negedge clk);
      start_i = 1'b1; rd_mode_i = rd; start_lba_i = lba; sector_cnt_i = n; patt_sel_i = sel;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // Write scenario: checks stream, pausing, length and byte count
   task automatic run_write(input string req, input logic [47:0] lba, input int n,
                            input logic [2:0] sel, input int afull_per, input int restart_at);
      int words = 0;
      int bad_data = 0;
      int bad_pause = 0;
      int c = 0;
      logic [31:0] first_bad_act = '0;
      logic [31:0] first_bad_exp = '0;
      logic [31:0] e;
      pulse_start(1'b0, lba, 48'(n), sel);
      while (busy_o && c < 5000) begin
         wr_afull_i = (afull_per != 0) && (c % afull_per == 1);
         start_i = (c == restart_at);
         if (c == restart_at) begin
            start_lba_i = 48'h0000_0BAD_0000; sector_cnt_i = 48'd9; patt_sel_i = 3'b011;
         end
         #1;
         if (wr_afull_i && wr_en_o) bad_pause++;
         if (wr_en_o) begin
            e = model(lba + 48'(words / 128), words % 128, sel);
            if (wr_data_o !== e) begin
               if (bad_data == 0) begin first_bad_act = wr_data_o; first_bad_exp = e; end
               bad_data++;
            end
            words++;
         end
         @(negedge clk);
         c++;
      end
      start_i = 1'b0;
      wr_afull_i = 1'b0;
      check(bad_data == 0, req, "write stream word", 64'(first_bad_act), 64'(first_bad_exp));
      check(bad_pause == 0, "R3", "write enable during almost-full", 64'(bad_pause), 64'd0);
      check(words == n * 128, "R5", "enabled word count", 64'(words), 64'(n * 128));
      check(tested_bytes_o == 57'(n * 512), "R5", "tested bytes", 64'(tested_bytes_o), 64'(n * 512));
      check(!busy_o && !wr_en_o, "R5", "busy after end", 64'(busy_o), 64'd0);
   endtask

   // Read scenario: feeds a show-ahead FIFO with optional corrupted words
   task automatic run_read(input logic [47:0] lba, input int n, input logic [2:0] sel,
                           input int gap_per, input int bad_a, input int bad_b);
      int k = 0;
      int c = 0;
      int bad_gate = 0;
      int wr_in_rd = 0;
      pulse_start(1'b1, lba, 48'(n), sel);
      check(fail_o == 1'b0, "R10", "fail cleared by start", 64'(fail_o), 64'd0);
      while (busy_o && c < 5000) begin
         rd_empty_i = (gap_per != 0) && (c % gap_per == 1);
         rd_data_i = model(lba + 48'(k / 128), k % 128, sel)
                     ^ (((k == bad_a) || (k == bad_b)) ? 32'h0000_0100 : 32'h0);
         #1;
         if (rd_empty_i && rd_en_o) bad_gate++;
         if (wr_en_o) wr_in_rd++;
         if (rd_en_o) k++;
         @(negedge clk);
         c++;
      end
      rd_empty_i = 1'b1;
      check(bad_gate == 0, "R4", "read enable while empty", 64'(bad_gate), 64'd0);
      check(wr_in_rd == 0, "R4", "write enable in read mode", 64'(wr_in_rd), 64'd0);
      check(k == n * 128, "R5", "words drained", 64'(k), 64'(n * 128));
      if (bad_a < 0) begin
         check(fail_o == 1'b0, "R10", "clean read fail flag", 64'(fail_o), 64'd0);
         check(fail_addr_o == '0, "R10", "capture cleared", 64'(fail_addr_o), 64'd0);
      end else begin
         logic [47:0] flba;
         logic [56:0] faddr;
         logic [31:0] fexp;
         flba  = lba + 48'(bad_a / 128);
         faddr = {flba, 7'(bad_a % 128), 2'b00};
         fexp  = model(flba, bad_a % 128, sel);
         check(fail_o == 1'b1, "R9", "fail flag", 64'(fail_o), 64'd1);
         check(fail_addr_o == faddr, "R9", "first fail byte address", 64'(fail_addr_o), 64'(faddr));
         check(fail_exp_o == fexp, "R9", "captured expected", 64'(fail_exp_o), 64'(fexp));
         check(fail_got_o == (fexp ^ 32'h100), "R9", "captured received", 64'(fail_got_o),
               64'(fexp ^ 32'h100));
      end
   endtask

   task automatic run_zero_len();
      int en_seen = 0;
      pulse_start(1'b0, 48'h10, 48'd0, 3'b000);
      for (int i = 0; i < 10; i++) begin
         #1;
         if (busy_o || wr_en_o || rd_en_o) en_seen++;
         @(negedge clk);
      end
      check(en_seen == 0, "R2", "zero length activity", 64'(en_seen), 64'd0);
   endtask

   task automatic run_reset_check();
      rd_empty_i = 1'b0;
      repeat (3) @(negedge clk);
      check(!busy_o && !wr_en_o && !rd_en_o, "R1", "enables in reset",
            64'({busy_o, wr_en_o, rd_en_o}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!fail_o && tested_bytes_o == '0 && !rd_en_o, "R1", "state after reset",
            64'(tested_bytes_o), 64'd0);
      rd_empty_i = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      run_reset_check();
      run_write("R6 R7 increment", 48'h0ABC_1234_5670, 3, 3'b000, 4, -1);
      run_write("R6 R7 decrement", 48'h0000_FFFF_FFFF, 2, 3'b001, 0, -1);
      run_write("R7 zeros", 48'h0000_0000_0042, 1, 3'b010, 3, -1);
      run_write("R7 ones", 48'h0000_0000_0043, 1, 3'b011, 0, -1);
      run_write("R7 unused code", 48'h0000_0000_0044, 1, 3'b110, 0, -1);
      run_write("R8 lfsr", 48'h0001_8000_0001, 2, 3'b100, 5, -1);
      run_zero_len();
      run_write("R11 restart ignored", 48'h0000_2222_0000, 2, 3'b000, 0, 40);
      run_read(48'h0000_0700_0000, 2, 3'b100, 3, 5, 200);
      run_read(48'h0000_0000_0900, 1, 3'b000, 0, -1, -1);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule